// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block recovers asynchronous serial characters from a single line, using a clock enable that pulses at sixteen times the bit rate. The raw line first passes through a two-stage synchronizer. While the receiver is idle, a high-to-low transition on the synchronized line starts a tick counter. Eight ticks later the line should be at the middle of the start bit. If the line is still low at that point, the start bit is accepted. If the line has already gone back high, the event is discarded as noise.

Once a start bit is accepted, each data bit is sampled in its centre, sixteen ticks after the previous sample. The stop bit is sampled the same way. The character is then presented, right-aligned, together with a framing error flag and a break flag, qualified by a one-cycle valid strobe. A two-bit code, captured at the accepted start bit, selects 5, 6, 7 or 8 data bits. Buffering, host-visible registers and the generation of the tick are left to the surrounding logic.

Top module: `serial_rx16`

## Requirements
- R1: After reset, `rx_valid` is 0, `rx_byte` is 0x00, and both `rx_frame_err` and `rx_break` are 0.
- R2: A low pulse on `rx_line` that is high again when the eighth tick after its falling edge arrives is rejected. No `rx_valid` pulse follows from it.
- R3: After a rejected start, the receiver hunts for the next falling edge again and receives the following character normally.
- R4: Data bits arrive least significant bit first. Bit k is placed at `rx_byte[k]`, and each bit is sampled sixteen ticks after the previous one.
- R5: `word_len` code 0, 1, 2 and 3 selects 5, 6, 7 and 8 data bits. Bits of `rx_byte` at and above the selected length read 0.
- R6: When the stop-bit sample is high, the character is delivered with `rx_frame_err` = 0 and `rx_break` = 0.
- R7: When the stop-bit sample is low, `rx_frame_err` = 1 is delivered with the character.
- R8: When every data-bit sample and the stop-bit sample are low, `rx_break` = 1 and `rx_frame_err` = 1, and `rx_byte` is 0x00.
- R9: `rx_valid` is a single-cycle pulse, issued exactly once per accepted character. Between pulses, `rx_byte` and the flags hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable pulse at sixteen times the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| word_len | input | 2 | Data-bit count code (0..3 selects 5..8 bits) |
| rx_byte | output | 8 | Received character, right-aligned |
| rx_valid | output | 1 | One-cycle strobe marking a new character |
| rx_frame_err | output | 1 | Stop bit was sampled low |
| rx_break | output | 1 | All data bits and the stop bit were low |

## Verification
Characters are sent with asymmetric bit patterns such as 0xA5 and 0x3C. Bit reversal or a slip by one bit position would change these values visibly. Each of the shorter word lengths is fed a character with ones above the selected length, which shows whether those bits are masked or whether the stop bit is mistaken for data. A short low glitch is followed directly by a valid character, which separates rejecting a false start from hanging after one. A stop-low character with nonzero data and an all-low line are kept apart to distinguish a plain framing error from a break.

// File: rtl/serial_rx16.sv
module serial_rx16 #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx_line,
  input  logic [1:0] word_len,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       rx_frame_err,
  output logic       rx_break
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [1:0] {HUNT, START, DATA, STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [1:0]    len_q;
  logic [7:0]    shreg;
  logic          s1, s2, s3;

  wire fall     = s3 & ~s2;
  wire at_mid   = tick16 && cnt == MID;
  wire at_bit   = tick16 && cnt == LAST;
  wire last_bit = idx == (3'd4 + {1'b0, len_q});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= 3'b111;
    else        {s1, s2, s3} <= {rx_line, s1, s2};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= HUNT;
      cnt          <= '0;
      idx          <= '0;
      len_q        <= '0;
      shreg        <= '0;
      rx_byte      <= '0;
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
      rx_break     <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      unique case (st)
        HUNT:
          if (fall) begin
            st  <= START;
            cnt <= '0;
          end
        START:
          if (at_mid) begin
            if (!s2) begin
              st    <= DATA;
              cnt   <= '0;
              idx   <= '0;
              shreg <= '0;
              len_q <= word_len;
            end else begin
              st <= HUNT;
            end
          end else if (tick16) begin
            cnt <= cnt + 1'b1;
          end
        DATA:
          if (at_bit) begin
            shreg[idx] <= s2;
            cnt        <= '0;
            if (last_bit) st  <= STOP;
            else          idx <= idx + 1'b1;
          end else if (tick16) begin
            cnt <= cnt + 1'b1;
          end
        STOP:
          if (at_bit) begin
            rx_byte      <= shreg;
            rx_frame_err <= ~s2;
            rx_break     <= ~s2 && shreg == 8'h00;
            rx_valid     <= 1'b1;
            st           <= HUNT;
          end else if (tick16) begin
            cnt <= cnt + 1'b1;
          end
        default: st <= HUNT;
      endcase
    end
  end
endmodule

module serial_rx16_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic [7:0] rx_byte,
  input logic       rx_frame_err,
  input logic       rx_break,
  input logic [1:0] len_q
);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_byte) && $stable(rx_frame_err) && $stable(rx_break));

  a_r8_break_means_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_break |-> rx_frame_err && rx_byte == 8'h00);

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_byte >> (5 + len_q)) == 8'h00);
endmodule

bind serial_rx16 serial_rx16_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
  .rx_frame_err(rx_frame_err), .rx_break(rx_break), .len_q(len_q)
);

// File: tb/serial_rx16_tb.sv
module serial_rx16_tb_top;
  localparam int BITCLK = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16;
  logic       rx_line = 1'b1;
  logic [1:0] word_len = 2'd3;
  logic [7:0] rx_byte;
  logic       rx_valid, rx_frame_err, rx_break;
  logic [1:0] tdiv = '0;

  int checks = 0, errors = 0, nval = 0;
  logic [7:0] cap_byte = '0;
  logic       cap_fe = 1'b0, cap_brk = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick16 = (tdiv == 2'd3);

  serial_rx16 dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
    .word_len(word_len), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err), .rx_break(rx_break)
  );

  always @(negedge clk)
    if (rx_valid) begin
      nval++;
      cap_byte = rx_byte;
      cap_fe   = rx_frame_err;
      cap_brk  = rx_break;
    end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int clocks);
    rx_line = v;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic send(input int nbits, input logic [7:0] d, input logic stopv);
    hold(1'b0, BITCLK);
    for (int i = 0; i < nbits; i++) hold(d[i], BITCLK);
    hold(stopv, BITCLK);
    hold(1'b1, 3 * BITCLK);
  endtask

  task automatic t_reset;
    check(rx_valid == 1'b0, "R1 valid", rx_valid, 0);
    check(rx_byte == 8'h00, "R1 byte", rx_byte, 0);
    check(rx_frame_err == 1'b0 && rx_break == 1'b0, "R1 flags",
          {rx_frame_err, rx_break}, 0);
  endtask

  task automatic t_byte(input logic [7:0] d);
    int n0 = nval;
    word_len = 2'd3;
    send(8, d, 1'b1);
    check(nval == n0 + 1, "R9 one pulse", nval - n0, 1);
    check(cap_byte == d, "R4 data order", cap_byte, d);
    check(!cap_fe && !cap_brk, "R6 clean stop", {cap_fe, cap_brk}, 0);
  endtask

  task automatic t_len(input logic [1:0] code, input logic [7:0] d);
    int n0 = nval;
    int nb = 5 + code;
    logic [7:0] exp = d & 8'((1 << nb) - 1);
    word_len = code;
    send(nb, d, 1'b1);
    check(nval == n0 + 1, "R5 one char", nval - n0, 1);
    check(cap_byte == exp, "R5 length mask", cap_byte, exp);
    check(!cap_fe, "R5 stop after length", cap_fe, 0);
    word_len = 2'd3;
  endtask

  task automatic t_false_start;
    int n0 = nval;
    hold(1'b0, 24);
    hold(1'b1, 12 * BITCLK);
    check(nval == n0, "R2 glitch rejected", nval - n0, 0);
    send(8, 8'h96, 1'b1);
    check(nval == n0 + 1 && cap_byte == 8'h96, "R3 resume hunting", cap_byte, 8'h96);
  endtask

  task automatic t_frame_err;
    send(8, 8'h55, 1'b0);
    check(cap_byte == 8'h55, "R7 data kept", cap_byte, 8'h55);
    check(cap_fe && !cap_brk, "R7 framing only", {cap_fe, cap_brk}, 2'b10);
  endtask

  task automatic t_break;
    int n0 = nval;
    hold(1'b0, 10 * BITCLK);
    hold(1'b1, 3 * BITCLK);
    check(nval == n0 + 1, "R8 single report", nval - n0, 1);
    check(cap_byte == 8'h00 && cap_fe && cap_brk, "R8 break",
          {cap_byte, cap_fe, cap_brk}, 10'b0000000011);
  endtask

  initial begin
    #(100000 * 5);
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    t_reset;
    t_byte(8'hA5);
    t_byte(8'h3C);
    t_len(2'd0, 8'hFF);
    t_len(2'd1, 8'hEA);
    t_len(2'd2, 8'hD5);
    t_false_start;
    t_frame_err;
    t_byte(8'h01);
    t_break;
    t_byte(8'h80);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule